// File: doc/BRIEF.md
# Four-Product Multiply-Accumulate Unit

This unit multiplies four pairs of signed two's-complement operands in one sample. The four products are added in two levels: lanes 0 and 1 form one pair sum, lanes 2 and 3 form the other, and the two pair sums are then added into a single total. A mode input chooses what the unit presents. In sum mode it presents that total. In accumulate mode it adds the total to, or subtracts it from, a 44-bit running value that it keeps between samples.

The datapath has three register stages: one at the operand inputs, one after the pair adders, and one at the output. Each stage is switched in or out by its own static parameter, so the latency is anywhere from zero (purely combinational) to three cycles. A valid bit moves with each sample through the enabled stages. A per-sample clear restarts the accumulation with no bubble. A sticky flag reports a signed wrap of the running value.

Top module: `quad_mac`

## Requirements
- R1: In sum mode (acc_mode=0), a valid sample gives result = a0·b0 + a1·b1 + a2·b2 + a3·b3. The sum is exact and sign-extended to 44 bits.
- R2: Lane k of each operand bus sits at bits [18k+17:18k] and is signed two's complement. The extreme codes 0x20000 (−131072) and 0x1FFFF (131071) are handled exactly, including the largest total of 2^36.
- R3: In accumulate mode with add_sub=1 and acc_clr=0, a valid sample sets the running value to its previous value plus the four-product total. The result shows the new running value.
- R4: In accumulate mode with add_sub=0 and acc_clr=0, a valid sample sets the running value to its previous value minus the total.
- R5: In accumulate mode, a valid sample with acc_clr=1 loads 0 plus or minus the total (as add_sub selects) and clears the overflow flag.
- R6: The running value and the overflow flag change only on valid accumulate-mode samples. Sum-mode samples and cycles with in_valid=0 leave them unchanged, whatever the other inputs are.
- R7: ovf goes high on the accumulate sample whose signed 44-bit result wraps, meaning the true value lies outside [−2^43, 2^43−1]. It stays high through later samples of either mode until a clearing sample. A result of exactly −2^43 does not set it.
- R8: Each valid sample appears on out_valid/result/ovf exactly IN_REG+PIPE_REG+OUT_REG cycles after it was presented, in order and once only.
- R9: After reset, out_valid and ovf are 0 and the running value is 0, so an accumulate sample without clear starts from zero.
- R10: acc_clr has no effect on a sum-mode sample. The accumulation continues afterwards from where it stood.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks a sample on the inputs this cycle |
| acc_mode | input | 1 | 1 = accumulate, 0 = plain four-product sum |
| add_sub | input | 1 | 1 = add the total, 0 = subtract it (accumulate mode) |
| acc_clr | input | 1 | Restart accumulation from zero with this sample |
| opa | input | 4·OP_W | Four signed left operands, lane k at [OP_W·k +: OP_W] |
| opb | input | 4·OP_W | Four signed right operands, same lane layout |
| out_valid | output | 1 | A result is present this cycle |
| result | output | ACC_W | Sum or running value, signed |
| ovf | output | 1 | Sticky accumulate-overflow flag |

## Verification
Properties check on every clock the timing of out_valid against in_valid over the configured latency. They also check that the running value holds when no accumulate sample arrives, that the flag stays set until a clearing sample, that it rises only on such a sample, and that a clear always leaves it low. The arithmetic can only be shown by the bench's scenarios: exact sums at the extreme operand codes, add and subtract sequences, the wrap at the 2^43 boundary, and the clear being ignored in sum mode. The bench compares eight instances, one per bypass combination, against one wide-integer model.

// File: rtl/quad_mac_pkg.sv
`timescale 1ns/1ps
// Shared constants and the control bundle carried beside the data.
// Assumes the four lanes are grouped as two pairs.
package quad_mac_pkg;
    localparam int LANES = 4;
    localparam int PAIRS = LANES / 2;

    typedef struct packed {
        logic acc_mode;   // 1: accumulate, 0: sum
        logic add;        // 1: add, 0: subtract
        logic clr;        // restart accumulation
    } mac_ctl_t;

    localparam int CTL_W = $bits(mac_ctl_t);
endpackage

// File: rtl/mac_stage_reg.sv
`timescale 1ns/1ps
// Optional pipeline stage for a data bus and its valid bit.
// EN=1 gives one register cycle, EN=0 a plain wire.
// Data is loaded only with a valid sample, so it holds between samples.
module mac_stage_reg #(
    parameter int W  = 8,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] d_i,
    output logic         vld_o,
    output logic [W-1:0] d_o
);
    generate
        if (EN) begin : g_reg
            logic         vq;
            logic [W-1:0] dq;
            // Register valid every cycle and data on valid samples.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vq <= 1'b0;
                    dq <= '0;
                end else begin
                    vq <= vld_i;
                    if (vld_i) dq <= d_i;
                end
            end
            assign vld_o = vq;
            assign d_o   = dq;
        end else begin : g_thru
            logic unused_thru;
            assign unused_thru = clk ^ rst_n;
            assign vld_o = vld_i;
            assign d_o   = d_i;
        end
    endgenerate
endmodule

// File: rtl/mac_pair_mult.sv
`timescale 1ns/1ps
// Two signed multipliers and their adder, giving one pair sum of
// width 2*OP_W+1. Assumes two's-complement operands.
module mac_pair_mult #(
    parameter  int OP_W = 18,
    localparam int PRW  = 2 * OP_W,
    localparam int PW   = PRW + 1
) (
    input  logic signed [OP_W-1:0] a0,
    input  logic signed [OP_W-1:0] b0,
    input  logic signed [OP_W-1:0] a1,
    input  logic signed [OP_W-1:0] a1_unused_guard_n,
    input  logic signed [OP_W-1:0] b1,
    output logic signed [PW-1:0]   p
);
    logic signed [PRW-1:0] m0;
    logic signed [PRW-1:0] m1;
    logic                  unused_guard;

    assign unused_guard = ^a1_unused_guard_n;

    // Form both products at full width, then add with one growth bit.
    always_comb begin
        m0 = PRW'(a0) * PRW'(b0);
        m1 = PRW'(a1) * PRW'(b1);
        p  = {m0[PRW-1], m0} + {m1[PRW-1], m1};
    end
endmodule

// File: rtl/mac_accum.sv
`timescale 1ns/1ps
// Second-stage adder, 44-bit add/subtract accumulator, sticky overflow
// and the optional output register. The running value is kept in its
// own register, so accumulation works even when the output stage is
// bypassed. Assumes pair sums arrive sign-correct, width 2*OP_W+1.
module mac_accum
    import quad_mac_pkg::*;
#(
    parameter  int OP_W    = 18,
    parameter  int ACC_W   = 44,
    parameter  bit OUT_REG = 1'b1,
    localparam int PW      = 2 * OP_W + 1,
    localparam int ZW      = 2 * OP_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  mac_ctl_t             ctl_i,
    input  logic signed [PW-1:0] p0_i,
    input  logic signed [PW-1:0] p1_i,
    output logic                 vld_o,
    output logic [ACC_W-1:0]     res_o,
    output logic                 ovf_o
);
    localparam int MSB = ACC_W - 1;

    logic signed [ZW-1:0]    z;
    logic signed [ACC_W-1:0] zx, base, sum, acc_q;
    logic                    ov, flag_q, flag_nxt, take;
    logic [ACC_W-1:0]        out_val;
    logic                    out_flag;

    // Total of both pairs, then add or subtract against the running value.
    always_comb begin
        z    = ZW'(p0_i) + ZW'(p1_i);
        zx   = ACC_W'(z);
        base = ctl_i.clr ? '0 : acc_q;
        sum  = ctl_i.add ? (base + zx) : (base - zx);
        if (ctl_i.add)
            ov = (base[MSB] == zx[MSB]) && (sum[MSB] != base[MSB]);
        else
            ov = (base[MSB] != zx[MSB]) && (sum[MSB] != base[MSB]);
        take     = vld_i && ctl_i.acc_mode;
        flag_nxt = ctl_i.clr ? ov : (flag_q | ov);
        out_val  = ctl_i.acc_mode ? sum : zx;
        out_flag = ctl_i.acc_mode ? flag_nxt : flag_q;
    end

    // Running value and sticky flag move only on accumulate samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            flag_q <= 1'b0;
        end else if (take) begin
            acc_q  <= sum;
            flag_q <= flag_nxt;
        end
    end

    generate
        if (OUT_REG) begin : g_oreg
            logic             vq, fq;
            logic [ACC_W-1:0] rq;
            // Output register, loaded with each valid sample.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vq <= 1'b0;
                    rq <= '0;
                    fq <= 1'b0;
                end else begin
                    vq <= vld_i;
                    if (vld_i) begin
                        rq <= out_val;
                        fq <= out_flag;
                    end
                end
            end
            assign vld_o = vq;
            assign res_o = rq;
            assign ovf_o = fq;
        end else begin : g_ocomb
            assign vld_o = vld_i;
            assign res_o = out_val;
            assign ovf_o = out_flag;
        end
    endgenerate

    // R6
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(acc_q));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(take && ctl_i.clr)) |=> flag_q);

    // R7
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(take));

    // R5
    clr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ctl_i.clr) |=> !flag_q);
endmodule

// File: rtl/quad_mac.sv
`timescale 1ns/1ps
// Four-product multiply-accumulate unit. Operand stage, two pair
// multiplier-adders, pipeline stage, then second-stage adder with
// accumulator and output stage. Each stage is kept or bypassed by a
// static parameter; latency is the number of kept stages.
module quad_mac
    import quad_mac_pkg::*;
#(
    parameter int OP_W     = 18,
    parameter int ACC_W    = 44,
    parameter bit IN_REG   = 1'b1,
    parameter bit PIPE_REG = 1'b1,
    parameter bit OUT_REG  = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  acc_mode,
    input  logic                  add_sub,
    input  logic                  acc_clr,
    input  logic [LANES*OP_W-1:0] opa,
    input  logic [LANES*OP_W-1:0] opb,
    output logic                  out_valid,
    output logic [ACC_W-1:0]      result,
    output logic                  ovf
);
    localparam int PW  = 2 * OP_W + 1;
    localparam int OPS = LANES * OP_W;
    localparam int IW  = CTL_W + 2 * OPS;
    localparam int SW  = CTL_W + PAIRS * PW;
    localparam int LAT = int'(IN_REG) + int'(PIPE_REG) + int'(OUT_REG);

    mac_ctl_t         in_ctl, s1_ctl, s2_ctl;
    logic [IW-1:0]    s1_bus;
    logic [OPS-1:0]   s1_a, s1_b;
    logic             s1_vld, s2_vld;
    logic signed [PW-1:0] pp [PAIRS];
    logic [SW-1:0]    s2_bus;

    // Gather the per-sample controls.
    always_comb begin
        in_ctl.acc_mode = acc_mode;
        in_ctl.add      = add_sub;
        in_ctl.clr      = acc_clr;
    end

    mac_stage_reg #(.W(IW), .EN(IN_REG)) u_in_stage (
        .clk(clk), .rst_n(rst_n), .vld_i(in_valid),
        .d_i({in_ctl, opa, opb}), .vld_o(s1_vld), .d_o(s1_bus)
    );

    assign s1_ctl = s1_bus[IW-1 -: CTL_W];
    assign s1_a   = s1_bus[2*OPS-1 -: OPS];
    assign s1_b   = s1_bus[OPS-1:0];

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        mac_pair_mult #(.OP_W(OP_W)) u_pair (
            .a0(s1_a[(2*g)*OP_W +: OP_W]),
            .b0(s1_b[(2*g)*OP_W +: OP_W]),
            .a1(s1_a[(2*g+1)*OP_W +: OP_W]),
            .a1_unused_guard_n('0),
            .b1(s1_b[(2*g+1)*OP_W +: OP_W]),
            .p(pp[g])
        );
    end

    mac_stage_reg #(.W(SW), .EN(PIPE_REG)) u_pipe_stage (
        .clk(clk), .rst_n(rst_n), .vld_i(s1_vld),
        .d_i({s1_ctl, pp[1], pp[0]}), .vld_o(s2_vld), .d_o(s2_bus)
    );

    assign s2_ctl = s2_bus[SW-1 -: CTL_W];

    mac_accum #(.OP_W(OP_W), .ACC_W(ACC_W), .OUT_REG(OUT_REG)) u_accum (
        .clk(clk), .rst_n(rst_n), .vld_i(s2_vld), .ctl_i(s2_ctl),
        .p0_i(s2_bus[PW-1:0]), .p1_i(s2_bus[2*PW-1 -: PW]),
        .vld_o(out_valid), .res_o(result), .ovf_o(ovf)
    );

    logic [1:0] since_rst;
    // Count edges since reset release, saturating, for the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    generate
        if (LAT > 0) begin : g_lat_chk
            // R8
            lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(since_rst) >= LAT) |-> (out_valid == $past(in_valid, LAT)));
        end else begin : g_lat0_chk
            // R8
            lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == in_valid);
        end
    endgenerate
endmodule

// File: tb/test_quad_mac.sv
`timescale 1ns/1ps
// Drives eight instances (every bypass combination) with one stimulus
// and checks each against a wide-integer model, every clock.
module test_quad_mac;
    localparam int OP_W = 18;
    localparam int ACC_W = 44;
    localparam int NCFG = 8;
    localparam logic [OP_W-1:0] VMIN = 18'h20000;
    localparam logic [OP_W-1:0] VMAX = 18'h1FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, acc_mode = 1'b0, add_sub = 1'b1, acc_clr = 1'b0;
    logic [4*OP_W-1:0] opa = '0, opb = '0;

    logic             ov_w  [NCFG];
    logic [ACC_W-1:0] res_w [NCFG];
    logic             flg_w [NCFG];

    always #4 clk = ~clk;

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        quad_mac #(.OP_W(OP_W), .ACC_W(ACC_W),
                   .IN_REG(g % 2), .PIPE_REG((g / 2) % 2), .OUT_REG((g / 4) % 2))
        i_quad_mac (
            .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_mode(acc_mode),
            .add_sub(add_sub), .acc_clr(acc_clr), .opa(opa), .opb(opb),
            .out_valid(ov_w[g]), .result(res_w[g]), .ovf(flg_w[g])
        );
    end

    typedef struct { longint res; bit ovf; int cyc; string tag; } exp_t;
    exp_t expq [NCFG][$];

    int cyc = 0;
    int n_vec = 0;
    int n_bad = 0;
    longint m_acc = 0;
    bit m_flag = 1'b0;

    always @(posedge clk) cyc++;

    function automatic int lat_of(int g);
        return (g % 2) + ((g / 2) % 2) + ((g / 4) % 2);
    endfunction

    function automatic longint sx(logic [OP_W-1:0] v);
        longint r;
        r = $signed(v);
        return r;
    endfunction

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Present one input cycle and, for a valid sample, update the model.
    task automatic apply(bit v, bit md, bit as, bit cl,
                         logic [4*OP_W-1:0] a, logic [4*OP_W-1:0] b, string tag);
        longint z, base, s, lo, hi;
        logic [63:0] t;
        logic [ACC_W-1:0] t44;
        exp_t e;
        @(posedge clk);
        #1;
        in_valid = v; acc_mode = md; add_sub = as; acc_clr = cl; opa = a; opb = b;
        if (v) begin
            z = 0;
            for (int k = 0; k < 4; k++)
                z += sx(a[k*OP_W +: OP_W]) * sx(b[k*OP_W +: OP_W]);
            if (md) begin
                hi = (longint'(1) <<< (ACC_W - 1)) - 1;
                lo = -(longint'(1) <<< (ACC_W - 1));
                base = cl ? 0 : m_acc;
                s = as ? base + z : base - z;
                m_flag = cl ? (s > hi || s < lo) : (m_flag || s > hi || s < lo);
                t = s;
                t44 = t[ACC_W-1:0];
                m_acc = $signed(t44);
                e.res = m_acc;
            end else begin
                e.res = z;
            end
            e.ovf = m_flag;
            e.cyc = cyc;
            e.tag = tag;
            for (int g = 0; g < NCFG; g++) expq[g].push_back(e);
        end
    endtask

    function automatic logic [4*OP_W-1:0] rnd();
        logic [4*OP_W-1:0] r;
        for (int k = 0; k < 4; k++) r[k*OP_W +: OP_W] = OP_W'($urandom_range(0, 262143));
        return r;
    endfunction

    function automatic logic [4*OP_W-1:0] fill(logic [OP_W-1:0] v);
        return {4{v}};
    endfunction

    // Compare every instance's outputs with the model, between edges.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int g = 0; g < NCFG; g++) begin
                if (ov_w[g]) begin
                    if (expq[g].size() == 0) begin
                        n_bad++;
                        $display("FAIL R8 cfg%0d out_valid got 1 exp 0 (no sample pending)", g);
                    end else begin
                        exp_t e;
                        e = expq[g].pop_front();
                        n_vec++;
                        if (cyc != e.cyc + lat_of(g)) begin
                            n_bad++;
                            $display("FAIL R8 cfg%0d arrival cycle got %0d exp %0d", g, cyc, e.cyc + lat_of(g));
                        end
                        if (res_w[g] != e.res[ACC_W-1:0]) begin
                            n_bad++;
                            $display("FAIL %s cfg%0d result got %0d exp %0d", e.tag, g, $signed(res_w[g]), e.res);
                        end
                        if (flg_w[g] != e.ovf) begin
                            n_bad++;
                            $display("FAIL %s cfg%0d ovf got %0b exp %0b", e.tag, g, flg_w[g], e.ovf);
                        end
                    end
                end
            end
        end
    end

    initial begin
        #(8ns * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        report();
    end

    initial begin
        logic [4*OP_W-1:0] a, b;
        repeat (4) @(posedge clk);
        // R9: reset state of every instance
        @(negedge clk);
        for (int g = 0; g < NCFG; g++) begin
            n_vec++;
            if (ov_w[g] !== 1'b0 || flg_w[g] !== 1'b0) begin
                n_bad++;
                $display("FAIL R9 cfg%0d valid/ovf got %0b/%0b exp 0/0", g, ov_w[g], flg_w[g]);
            end
        end
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R9: accumulate without clear starts from zero
        apply(1, 1, 1, 0, fill(18'd3), fill(18'd5), "R9");

        // R1 and R2: sum mode, random and extreme operands
        for (int i = 0; i < 24; i++) apply(1, 0, 1, 0, rnd(), rnd(), "R1");
        apply(1, 0, 1, 0, fill(VMIN), fill(VMIN), "R2");
        apply(1, 0, 1, 0, fill(VMAX), fill(VMIN), "R2");
        apply(1, 0, 1, 0, fill(VMAX), fill(VMAX), "R2");
        apply(1, 0, 0, 0, {VMIN, VMAX, VMIN, VMAX}, {VMAX, VMIN, VMIN, VMAX}, "R2");
        apply(1, 0, 1, 0, {18'd0, 18'd0, 18'd0, 18'd7}, {18'd0, 18'd0, 18'd0, 18'h3FFFF}, "R2");

        // R5 then R3: clear and add, with bubbles
        apply(1, 1, 1, 1, rnd(), rnd(), "R5");
        for (int i = 0; i < 20; i++) begin
            if (i % 4 == 2) apply(0, 1, 0, 1, rnd(), rnd(), "R6");
            apply(1, 1, 1, 0, rnd(), rnd(), "R3");
        end
        // R4: subtract
        for (int i = 0; i < 20; i++) apply(1, 1, 0, 0, rnd(), rnd(), "R4");
        // R10: clear in sum mode is ignored, accumulation continues (R6)
        apply(1, 0, 1, 1, rnd(), rnd(), "R10");
        apply(1, 0, 0, 1, rnd(), rnd(), "R10");
        apply(1, 1, 1, 0, rnd(), rnd(), "R10");
        apply(0, 1, 1, 1, '0, '0, "R6");
        apply(1, 1, 0, 0, rnd(), rnd(), "R6");
        // Mixed random stream
        for (int i = 0; i < 60; i++)
            apply($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
                  $urandom_range(0, 9) == 0, rnd(), rnd(), "R3");

        // R7: positive wrap at 2^43, then stickiness across modes
        apply(1, 1, 1, 1, fill(VMIN), fill(VMIN), "R5");
        for (int i = 0; i < 130; i++) apply(1, 1, 1, 0, fill(VMIN), fill(VMIN), "R7");
        apply(1, 0, 1, 0, rnd(), rnd(), "R7");
        apply(1, 1, 0, 0, fill(18'd1), fill(18'd1), "R7");
        // R5: clear drops the flag
        apply(1, 1, 1, 1, rnd(), rnd(), "R5");
        // R7: negative boundary, exactly -2^43 keeps flag low, one more wraps
        apply(1, 1, 0, 1, fill(VMIN), fill(VMIN), "R5");
        for (int i = 0; i < 127; i++) apply(1, 1, 0, 0, fill(VMIN), fill(VMIN), "R7");
        a = {18'd0, 18'd0, 18'd0, 18'd1};
        b = {18'd0, 18'd0, 18'd0, 18'd1};
        apply(1, 1, 0, 0, a, b, "R7");
        apply(1, 1, 0, 1, rnd(), rnd(), "R5");

        repeat (6) apply(0, 0, 1, 0, '0, '0, "R8");
        @(negedge clk);
        for (int g = 0; g < NCFG; g++) begin
            n_vec++;
            if (expq[g].size() != 0) begin
                n_bad++;
                $display("FAIL R8 cfg%0d pending samples got %0d exp 0", g, expq[g].size());
            end
        end
        report();
    end
endmodule